// File: doc/BRIEF.md
# Bit-Serial USB PHY Tuning Register Port

This block is the digital side of a per-port tuning interface for up to four USB PHYs. Software sees one 32-bit control word on a simple synchronous write/read bus. That word carries an 8-bit tuning address, a single data bit and one strobe bit per port. Each time a port's strobe bit goes from 0 to 1, the data bit is stored into that port's 256-bit tuning array at the address held in the word.

Tuning values wider than one bit are sent one bit per strobe pulse. The least significant bit goes first, and bit i lands at address base+i. The block decodes a few well-known fields from each array and drives them out next to the raw arrays: transmit amplitude, disconnect threshold, squelch-detect enable and, for port 0 only, a resistor-calibration enable. Ports at or above the configured port count are present at the outputs but never accept a write.

Top module: `phy_tune_port`

## Requirements
- R1: After reset the control word reads zero and every bit of every tuning array is zero.
- R2: A read of the control word (bus_rdata) shows the last word written, starting the cycle after the write.
- R3: When control bit 2*n changes from 0 to 1, with n below NUM_PORTS, bit 7 of the word is stored in array n at the address in bits 15:8. The array bit changes one clock after the rising edge becomes visible in the control word.
- R4: A strobe bit that stays at 1 across writes, or that returns to 0, stores nothing. This includes a write of an all-zero word.
- R5: A write stores only into the ports whose strobe rose. Several strobes that rise in the same word each store the same bit at the same address in their own arrays.
- R6: A rising strobe for a port index at or above NUM_PORTS leaves that port's array at zero.
- R7: tx_amp for port n is array bits 0x24..0x20, with bit i taken from address 0x20+i.
- R8: disc_thr for port n is array bits 0x2b..0x2a, with bit i taken from address 0x2a+i.
- R9: squelch_en for port n is 1 exactly when array bits 0x3d..0x3c hold 0. The value 2 (bit 0x3d set) turns it off.
- R10: rescal_en is bit 0x0c of port 0's array. The same address in other ports does not affect it.
- R11: A store changes only the addressed bit. All other bits of that array keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Control word to write: address 15:8, data 7, strobe of port n at 2*n |
| bus_rdata | output | 32 | Current control word |
| tune_bits | output | 1024 | Tuning arrays, port n in bits 256*n+255 .. 256*n |
| tx_amp | output | 20 | Amplitude field, port n in bits 5*n+4 .. 5*n |
| disc_thr | output | 8 | Disconnect threshold, port n in bits 2*n+1 .. 2*n |
| squelch_en | output | 4 | Squelch detection enabled, one bit per port |
| rescal_en | output | 1 | Resistor calibration enable of port 0 |

## Verification
The bench holds a strobe high while it changes the address and data, and it writes all-zero words between bit sequences. A design that stores on the level of the strobe instead of its edge would overwrite the array during these steps. It raises two strobes in one word and aims writes at the unconfigured fourth port. A wrong port decode would show up as a write to the wrong array or as a nonzero unused slot. Multi-bit amplitude, threshold and squelch values are sent LSB first and checked against fields the bench computes from its own array model, so a reversed bit order or a shifted base address would give wrong field values. Random control words fill the rest of the address space, so a stray write to a neighbouring bit (R11) would also be caught.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  localparam int PORT_SLOTS = 4;
  localparam int CTRL_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int ADDR_LSB   = 8;
  localparam int DATA_POS   = 7;
  localparam int TUNE_BITS  = 1 << ADDR_W;

  localparam int AMP_BASE  = 'h20;
  localparam int AMP_W     = 5;
  localparam int DISC_BASE = 'h2a;
  localparam int DISC_W    = 2;
  localparam int SQ_BASE   = 'h3c;
  localparam int SQ_W      = 2;
  localparam int RCAL_ADDR = 'h0c;

  function automatic logic [PORT_SLOTS-1:0] strobe_bits(input logic [CTRL_W-1:0] w);
    logic [PORT_SLOTS-1:0] s;
    for (int i = 0; i < PORT_SLOTS; i++) s[i] = w[2*i];
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [CTRL_W-1:0] w);
    return w[ADDR_LSB +: ADDR_W];
  endfunction

  function automatic logic [PORT_SLOTS-1:0] live_mask(input int n);
    logic [PORT_SLOTS-1:0] m;
    for (int i = 0; i < PORT_SLOTS; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [AMP_W-1:0] amp_field(input logic [TUNE_BITS-1:0] b);
    logic [AMP_W-1:0] r;
    for (int i = 0; i < AMP_W; i++) r[i] = b[AMP_BASE + i];
    return r;
  endfunction

  function automatic logic [DISC_W-1:0] disc_field(input logic [TUNE_BITS-1:0] b);
    logic [DISC_W-1:0] r;
    for (int i = 0; i < DISC_W; i++) r[i] = b[DISC_BASE + i];
    return r;
  endfunction

  function automatic logic [SQ_W-1:0] squelch_field(input logic [TUNE_BITS-1:0] b);
    logic [SQ_W-1:0] r;
    for (int i = 0; i < SQ_W; i++) r[i] = b[SQ_BASE + i];
    return r;
  endfunction
endpackage

// File: rtl/phy_tune_ctrl.sv
module phy_tune_ctrl
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CTRL_W-1:0]     wdata,
  output logic [CTRL_W-1:0]     ctrl_q,
  output logic [PORT_SLOTS-1:0] commit,
  output logic [ADDR_W-1:0]     cmt_addr,
  output logic                  cmt_data
);
  localparam logic [PORT_SLOTS-1:0] LIVE = live_mask(NUM_PORTS);

  logic [PORT_SLOTS-1:0] prev_q;
  logic [PORT_SLOTS-1:0] rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      prev_q <= '0;
    end else begin
      if (wr_en) ctrl_q <= wdata;
      prev_q <= strobe_bits(ctrl_q);
    end
  end

  assign rise     = strobe_bits(ctrl_q) & ~prev_q;
  assign commit   = rise & LIVE;
  assign cmt_addr = word_addr(ctrl_q);
  assign cmt_data = ctrl_q[DATA_POS];
endmodule

// File: rtl/phy_tune_bank.sv
module phy_tune_bank
  import phy_tune_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 din,
  output logic [TUNE_BITS-1:0] bits_q,
  output logic [AMP_W-1:0]     amp,
  output logic [DISC_W-1:0]    disc,
  output logic                 sq_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else if (we) bits_q[addr] <= din;
  end

  assign amp   = amp_field(bits_q);
  assign disc  = disc_field(bits_q);
  assign sq_en = (squelch_field(bits_q) == '0);
endmodule

// File: rtl/phy_tune_port.sv
module phy_tune_port
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr_en,
  input  logic [31:0]                       bus_wdata,
  output logic [31:0]                       bus_rdata,
  output logic [PORT_SLOTS*TUNE_BITS-1:0]   tune_bits,
  output logic [PORT_SLOTS*AMP_W-1:0]       tx_amp,
  output logic [PORT_SLOTS*DISC_W-1:0]      disc_thr,
  output logic [PORT_SLOTS-1:0]             squelch_en,
  output logic                              rescal_en
);
  logic [PORT_SLOTS-1:0] commit_vec;
  logic [ADDR_W-1:0]     cmt_addr;
  logic                  cmt_data;

  phy_tune_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .wdata    (bus_wdata),
    .ctrl_q   (bus_rdata),
    .commit   (commit_vec),
    .cmt_addr (cmt_addr),
    .cmt_data (cmt_data)
  );

  for (genvar p = 0; p < PORT_SLOTS; p++) begin : g_port
    phy_tune_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (commit_vec[p]),
      .addr   (cmt_addr),
      .din    (cmt_data),
      .bits_q (tune_bits[p*TUNE_BITS +: TUNE_BITS]),
      .amp    (tx_amp[p*AMP_W +: AMP_W]),
      .disc   (disc_thr[p*DISC_W +: DISC_W]),
      .sq_en  (squelch_en[p])
    );
  end

  assign rescal_en = tune_bits[RCAL_ADDR];
endmodule

// File: rtl/phy_tune_chk.sv
module phy_tune_chk
  import phy_tune_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_wr_en,
  input logic [31:0]                     bus_wdata,
  input logic [31:0]                     bus_rdata,
  input logic [PORT_SLOTS-1:0]           commit,
  input logic [PORT_SLOTS*TUNE_BITS-1:0] tune_bits
);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |=> bus_rdata == $past(bus_wdata));

  a_r4_quiet_array: assert property (@(posedge clk) disable iff (!rst_n)
    (commit == '0) |=> $stable(tune_bits));

  for (genvar p = 0; p < PORT_SLOTS; p++) begin : g_chk
    logic [TUNE_BITS-1:0] slice;
    assign slice = tune_bits[p*TUNE_BITS +: TUNE_BITS];

    if (p < NUM_PORTS) begin : g_live
      a_r3_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        commit[p] |-> bus_rdata[2*p] && !$past(bus_rdata[2*p]));

      a_r3_stored_value: assert property (@(posedge clk) disable iff (!rst_n)
        commit[p] |=> slice[$past(bus_rdata[15:8])] == $past(bus_rdata[7]));
    end else begin : g_dead
      a_r6_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slice == '0);
    end
  end
endmodule

bind phy_tune_port phy_tune_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr_en (bus_wr_en),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .commit    (commit_vec),
  .tune_bits (tune_bits)
);

// File: tb/sim_phy_tune_port.sv
module sim_phy_tune_port;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr_en;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [1023:0] tune_bits;
  logic [19:0]   tx_amp;
  logic [7:0]    disc_thr;
  logic [3:0]    squelch_en;
  logic          rescal_en;

  int checks = 0;
  int fails  = 0;

  logic [255:0] m_arr [4];
  logic [3:0]   m_prev;
  logic [31:0]  m_ctrl;

  always #2 clk = ~clk;

  phy_tune_port #(.NUM_PORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tune_bits(tune_bits), .tx_amp(tx_amp),
    .disc_thr(disc_thr), .squelch_en(squelch_en), .rescal_en(rescal_en)
  );

  function automatic logic [4:0] exp_amp(input logic [255:0] a);
    return {a[36], a[35], a[34], a[33], a[32]};
  endfunction
  function automatic logic [1:0] exp_disc(input logic [255:0] a);
    return {a[43], a[42]};
  endfunction
  function automatic logic exp_sq(input logic [255:0] a);
    return !(a[61] | a[60]);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic check_all(input string tag);
    chk("R2", "rdata", 256'(bus_rdata), 256'(m_ctrl));
    for (int n = 0; n < 4; n++) begin
      chk((n >= NP) ? "R6" : tag, $sformatf("array%0d", n),
          tune_bits[n*256 +: 256], m_arr[n]);
      chk("R7", $sformatf("amp%0d", n), 256'(tx_amp[n*5 +: 5]), 256'(exp_amp(m_arr[n])));
      chk("R8", $sformatf("disc%0d", n), 256'(disc_thr[n*2 +: 2]), 256'(exp_disc(m_arr[n])));
      chk("R9", $sformatf("squelch%0d", n), 256'(squelch_en[n]), 256'(exp_sq(m_arr[n])));
    end
    chk("R10", "rescal", 256'(rescal_en), 256'(m_arr[0][12]));
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk);
    bus_wr_en = 1'b1;
    bus_wdata = w;
    @(negedge clk);
    bus_wr_en = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 4; n++) begin
      if (n < NP && w[2*n] && !m_prev[n]) m_arr[n][w[15:8]] = w[7];
      m_prev[n] = w[2*n];
    end
    m_ctrl = w;
  endtask

  task automatic send_value(input int port, input int base, input int val,
                            input int len, input bit clear_first, input string tag);
    if (clear_first) bus_write(32'h0);
    for (int i = 0; i < len; i++) begin
      logic [31:0] w;
      w = (32'((base + i) & 8'hff) << 8) | (32'((val >> i) & 1) << 7);
      bus_write(w);
      bus_write(w | (32'h1 << (2*port)));
      bus_write(w);
    end
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    for (int n = 0; n < 4; n++) m_arr[n] = '0;
    m_prev = '0;
    m_ctrl = '0;
    rst_n = 1'b0;
    bus_wr_en = 1'b0;
    bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R10 resistor calibration bit on port 0, R7 amplitude on every live port
    send_value(0, 'h0c, 1, 1, 1'b1, "R10");
    for (int p = 0; p < NP; p++) send_value(p, 'h20, 'h14, 5, 1'b1, "R3");
    // R8 disconnect threshold, R9 squelch off then on again
    send_value(1, 'h2a, 3, 2, 1'b1, "R8");
    send_value(2, 'h3c, 2, 2, 1'b1, "R9");
    send_value(2, 'h3c, 0, 2, 1'b1, "R9");
    // R10: same address on port 1 must not drive rescal_en
    send_value(1, 'h0c, 1, 1, 1'b0, "R10");
    send_value(0, 'h0c, 0, 1, 1'b0, "R10");
    // R6: port 3 strobe is beyond NUM_PORTS
    send_value(3, 'h20, 'h1f, 5, 1'b1, "R6");

    // R4: strobe held high while address and data change, then all-zero word
    bus_write(32'h0000_5081);
    check_all("R3");
    bus_write(32'h0000_6001);
    bus_write(32'h0000_7081);
    check_all("R4");
    bus_write(32'h0);
    check_all("R4");

    // R5: two strobes rising in one word
    bus_write(32'h0000_9985);
    check_all("R5");
    bus_write(32'h0000_9904);
    check_all("R5");

    // R11 and general: random control words
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 4 == 0) w = w & 32'hffff_ff80;
      bus_write(w);
      check_all("R11");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule